// File: doc/BRIEF.md
# SPI Master with Programmable Select Timing

This block is a single-slave SPI master that runs one serial frame for each command it accepts. A command carries the transmit word and a frame length of 4 to 16 bits. It also carries four per-frame flags: bit order, clock polarity, clock phase, and a flag that asks chip select to stay asserted into the next frame. Commands enter through a valid/ready handshake. The word captured from the serial input leaves on a one-cycle valid strobe.

Four static inputs shape the waveform, all counted in system clocks:
- the serial-clock half period;
- the wait from chip select asserting to the first serial-clock edge;
- the wait from the last edge to chip select releasing;
- the minimum time chip select stays released before the next frame.

A count of zero acts as one. A frame of N bits produces 2N serial-clock edges. The clock phase decides whether data is launched on odd or even edges and sampled on the others. When a frame asks to keep select and the next command is already waiting as the trailing wait expires, that command is taken at once. Chip select then never rises between the two frames.

Top module: `spi_frame_master`

## Requirements
- R1: Out of reset, spi_cs_n is 1, spi_sclk is 0, cmd_ready is 1 and rx_valid is 0. A command is taken on a clock where cmd_valid and cmd_ready are both 1. cmd_ready is 0 while a frame or its trailing wait or idle gap is running, except for the single chaining cycle of R9.
- R2: spi_cs_n goes low on the clock that takes a command, and spi_sclk moves at that same clock to the command's polarity level. The first serial-clock edge comes exactly max(cfg_lead,1) clocks after the command is taken.
- R3: Successive serial-clock edges are max(cfg_half,1) clocks apart. A frame of N bits has exactly 2N edges and leaves spi_sclk at the polarity level. A cmd_len below 4 is treated as 4, and a cmd_len above 16 is treated as 16.
- R4: With cmd_cpha = 0, the first data bit appears on spi_mosi on the clock the command is taken. spi_miso is sampled on edges 1, 3, 5 and so on. spi_mosi moves to the next bit on edges 2, 4, … 2N-2.
- R5: With cmd_cpha = 1, spi_mosi is 0 from acceptance until edge 1, and the first bit appears on edge 1. spi_mosi moves on edges 1, 3, … 2N-1, and spi_miso is sampled on edges 2, 4, … 2N.
- R6: With cmd_lsb_first = 0, bit N-1 of cmd_word is sent first, and the first bit received lands in rx_word bit N-1. With cmd_lsb_first = 1, bit 0 is sent first and the first bit received lands in bit 0. Bits N and above of rx_word are 0. spi_mosi holds the last bit sent until the next command is taken.
- R7: spi_cs_n returns to 1 exactly max(cfg_trail,1) clocks after the last serial-clock edge, unless the frame is chained as in R9.
- R8: After spi_cs_n returns to 1, cmd_ready stays 0 for max(cfg_gap,1) clocks, so chip select stays released at least that long.
- R9: If the frame had cmd_hold_cs = 1, cmd_ready is 1 in the last clock of the trailing wait. A command offered then is taken, spi_cs_n stays 0, and the new frame starts with its own lead wait.
- R10: If the frame had cmd_hold_cs = 1 but no command is offered in that clock, spi_cs_n rises exactly as in R7 and the idle gap of R8 follows.
- R11: rx_valid is 1 for exactly one clock, starting on the clock of edge 2N. In that clock rx_word holds the complete received frame.
- R12: A cfg_half, cfg_lead, cfg_trail or cfg_gap value of 0 gives the same timing as a value of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this clock |
| cmd_word | input | 16 | Word to transmit |
| cmd_len | input | 5 | Frame length in bits (clamped to 4..16) |
| cmd_lsb_first | input | 1 | 1: least significant bit first |
| cmd_cpol | input | 1 | Idle level of the serial clock |
| cmd_cpha | input | 1 | 0: sample odd edges, 1: sample even edges |
| cmd_hold_cs | input | 1 | Keep chip select asserted into a waiting next frame |
| cfg_half | input | 8 | Serial-clock half period in system clocks |
| cfg_lead | input | 8 | Select-to-first-edge wait |
| cfg_trail | input | 8 | Last-edge-to-release wait |
| cfg_gap | input | 8 | Minimum released time between frames |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| rx_valid | output | 1 | Received word valid strobe |
| rx_word | output | 16 | Received word, right-aligned |

## Verification
The hardest case to reach from the ports is the chained frame. cmd_ready rises for a single clock at the tail of the trailing wait, and only when the running frame asked to keep select. The bench therefore offers the follow-on command straight after the first one is taken and holds it until that one-clock window opens. It does this for a chain of three frames, and again with the flag set but nothing offered, so that both R9 and R10 are covered. A second hard spot is the alignment between the edge on which spi_miso is sampled and the bit the bench presents there. The bench drives spi_miso from its own count of edges already made, so a one-edge skew in either phase mode corrupts rx_word.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_GAP
  } phase_t;

  // A wait of v clocks loads the down-counter with v-1; zero behaves as one.
  function automatic int span_load(input int v);
    return (v < 1) ? 0 : v - 1;
  endfunction

  // Frame length limited to the range 4..hi.
  function automatic int clamp_len(input int v, input int hi);
    if (v < 4) return 4;
    if (v > hi) return hi;
    return v;
  endfunction

  // Position in the data word of the idx-th bit on the wire.
  function automatic int bit_slot(input int idx, input int len, input bit lsb_first);
    return lsb_first ? idx : (len - 1 - idx);
  endfunction

  // Serial-clock edges in a frame of len bits.
  function automatic int frame_edges(input int len);
    return 2 * len;
  endfunction

endpackage

// File: rtl/spi_fm_timer.sv
module spi_fm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/spi_fm_shifter.sv
module spi_fm_shifter #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] start_word,
  input  logic [IDX_W-1:0]  start_len,
  input  logic              start_lsb,
  input  logic              start_cpha,
  input  logic              launch,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  import spi_fm_pkg::*;

  localparam int SEL_W = $clog2(DATA_W);

  logic [DATA_W-1:0] tx_q, rx_q;
  logic [IDX_W-1:0]  len_q, tx_i, rx_i;
  logic              lsb_q, mosi_q;
  logic [SEL_W-1:0]  first_sel, tx_sel, rx_sel;

  assign first_sel = SEL_W'(bit_slot(0, int'(start_len), start_lsb));
  assign tx_sel    = SEL_W'(bit_slot(int'(tx_i), int'(len_q), lsb_q));
  assign rx_sel    = SEL_W'(bit_slot(int'(rx_i), int'(len_q), lsb_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      len_q  <= '0;
      tx_i   <= '0;
      rx_i   <= '0;
      lsb_q  <= 1'b0;
      mosi_q <= 1'b0;
    end else if (start) begin
      tx_q  <= start_word;
      len_q <= start_len;
      lsb_q <= start_lsb;
      rx_q  <= '0;
      rx_i  <= '0;
      if (start_cpha) begin
        mosi_q <= 1'b0;
        tx_i   <= '0;
      end else begin
        mosi_q <= start_word[first_sel];
        tx_i   <= IDX_W'(1);
      end
    end else begin
      if (launch) begin
        mosi_q <= tx_q[tx_sel];
        tx_i   <= tx_i + 1'b1;
      end
      if (sample) begin
        rx_q[rx_sel] <= miso;
        rx_i         <= rx_i + 1'b1;
      end
    end
  end

  assign mosi    = mosi_q;
  assign rx_word = rx_q;

  // R6: every launched or sampled bit falls inside the frame
  a_r6_launch_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !start) |-> (tx_i < len_q));
  a_r6_sample_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !start) |-> (rx_i < len_q));

endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [DATA_W-1:0]            cmd_word,
  input  logic [$clog2(DATA_W+1)-1:0]  cmd_len,
  input  logic                         cmd_lsb_first,
  input  logic                         cmd_cpol,
  input  logic                         cmd_cpha,
  input  logic                         cmd_hold_cs,
  input  logic [DIV_W-1:0]             cfg_half,
  input  logic [CNT_W-1:0]             cfg_lead,
  input  logic [CNT_W-1:0]             cfg_trail,
  input  logic [CNT_W-1:0]             cfg_gap,
  output logic                         spi_cs_n,
  output logic                         spi_sclk,
  output logic                         spi_mosi,
  input  logic                         spi_miso,
  output logic                         rx_valid,
  output logic [DATA_W-1:0]            rx_word
);
  import spi_fm_pkg::*;

  localparam int IDX_W  = $clog2(DATA_W + 1);
  localparam int EDGE_W = $clog2(2 * DATA_W + 1);
  localparam int TMR_W  = (CNT_W > DIV_W) ? CNT_W : DIV_W;

  phase_t              phase_q;
  logic                cs_n_q, sclk_q, rx_valid_q;
  logic [EDGE_W-1:0]   edge_q, edge_num, edge_total;
  logic [IDX_W-1:0]    len_q, acc_len;
  logic                cpol_q, cpha_q, hold_q;

  logic                tmr_load, tmr_done;
  logic [TMR_W-1:0]    tmr_val;

  // named internal events
  logic accept, lead_done, fire_edge, last_edge, trail_done, gap_done;
  logic ev_launch, ev_sample;

  assign acc_len    = IDX_W'(clamp_len(int'(cmd_len), DATA_W));
  assign edge_total = EDGE_W'(frame_edges(int'(len_q)));
  assign edge_num   = edge_q + 1'b1;

  assign lead_done  = (phase_q == ST_LEAD)  && tmr_done;
  assign trail_done = (phase_q == ST_TRAIL) && tmr_done;
  assign gap_done   = (phase_q == ST_GAP)   && tmr_done;
  assign fire_edge  = lead_done || ((phase_q == ST_SHIFT) && tmr_done);
  assign last_edge  = fire_edge && (edge_num == edge_total);

  assign cmd_ready  = (phase_q == ST_IDLE) || (trail_done && hold_q);
  assign accept     = cmd_valid && cmd_ready;

  assign ev_launch  = fire_edge && (cpha_q ? edge_num[0] : (!edge_num[0] && !last_edge));
  assign ev_sample  = fire_edge && (cpha_q ? !edge_num[0] : edge_num[0]);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(span_load(int'(cfg_lead)));
    end else if (fire_edge) begin
      tmr_load = 1'b1;
      tmr_val  = last_edge ? TMR_W'(span_load(int'(cfg_trail)))
                           : TMR_W'(span_load(int'(cfg_half)));
    end else if (trail_done) begin
      tmr_load = 1'b1;
      tmr_val  = TMR_W'(span_load(int'(cfg_gap)));
    end
  end

  spi_fm_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  spi_fm_shifter #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_word (cmd_word),
    .start_len  (acc_len),
    .start_lsb  (cmd_lsb_first),
    .start_cpha (cmd_cpha),
    .launch     (ev_launch),
    .sample     (ev_sample),
    .miso       (spi_miso),
    .mosi       (spi_mosi),
    .rx_word    (rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= ST_IDLE;
      cs_n_q     <= 1'b1;
      sclk_q     <= 1'b0;
      edge_q     <= '0;
      rx_valid_q <= 1'b0;
      len_q      <= '0;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
      hold_q     <= 1'b0;
    end else begin
      rx_valid_q <= last_edge;
      if (accept) begin
        phase_q <= ST_LEAD;
        cs_n_q  <= 1'b0;
        sclk_q  <= cmd_cpol;
        edge_q  <= '0;
        len_q   <= acc_len;
        cpol_q  <= cmd_cpol;
        cpha_q  <= cmd_cpha;
        hold_q  <= cmd_hold_cs;
      end else if (fire_edge) begin
        sclk_q  <= ~sclk_q;
        edge_q  <= edge_num;
        phase_q <= last_edge ? ST_TRAIL : ST_SHIFT;
      end else if (trail_done) begin
        cs_n_q  <= 1'b1;
        phase_q <= ST_GAP;
      end else if (gap_done) begin
        phase_q <= ST_IDLE;
      end
    end
  end

  assign spi_cs_n = cs_n_q;
  assign spi_sclk = sclk_q;
  assign rx_valid = rx_valid_q;

  // R1: select only falls after a completed handshake
  a_r1_select_follows_handshake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> $past(cmd_valid && cmd_ready));
  // R2: the serial clock is quiet during the lead wait
  a_r2_lead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == ST_LEAD && !tmr_done) |=> $stable(sclk_q));
  // R3: the frame ends with the clock back at its idle level
  a_r3_idle_level_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_q |-> (sclk_q == cpol_q));
  // R4 / R5: serial data out only moves on a take or on a launch edge
  a_r5_mosi_moves_on_events: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_mosi) |-> $past(accept || ev_launch));
  // R7: release happens with the clock parked at idle level
  a_r7_release_at_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> (sclk_q == cpol_q));
  // R8: no command is taken right after release
  a_r8_gap_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_q) |-> !cmd_ready);
  // R9: a chained command keeps select asserted
  a_r9_chain_keeps_select: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_done && hold_q && cmd_valid) |=> !cs_n_q);
  // R10: without a chained command select is released
  a_r10_unchained_release: assert property (@(posedge clk) disable iff (!rst_n)
    (trail_done && !(hold_q && cmd_valid)) |=> cs_n_q);
  // R11: received-word strobe lasts one clock
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_q |=> !rx_valid_q);

endmodule

// File: tb/spi_frame_master_tb.sv
module spi_frame_master_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_word = '0;
  logic [4:0]  cmd_len = 5'd8;
  logic        cmd_lsb_first = 1'b0, cmd_cpol = 1'b0, cmd_cpha = 1'b0, cmd_hold_cs = 1'b0;
  logic [7:0]  cfg_half = 8'd1, cfg_lead = 8'd1, cfg_trail = 8'd1, cfg_gap = 8'd1;
  logic        spi_cs_n, spi_sclk, spi_mosi;
  logic        spi_miso = 1'b0;
  logic        rx_valid;
  logic [15:0] rx_word;

  always #2 clk = ~clk;  // 250 MHz

  spi_frame_master u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .cmd_len(cmd_len), .cmd_lsb_first(cmd_lsb_first),
    .cmd_cpol(cmd_cpol), .cmd_cpha(cmd_cpha), .cmd_hold_cs(cmd_hold_cs),
    .cfg_half(cfg_half), .cfg_lead(cfg_lead), .cfg_trail(cfg_trail), .cfg_gap(cfg_gap),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .rx_valid(rx_valid), .rx_word(rx_word)
  );

  int    n_cmp = 0, n_bad = 0;
  string cur_tag = "R1";
  bit    finished = 1'b0;

  function automatic int at_least1(int v); return (v < 1) ? 1 : v; endfunction
  function automatic int fit_len(int v); return (v < 4) ? 4 : ((v > 16) ? 16 : v); endfunction
  function automatic int wire_pos(int i, int n, bit lsb); return lsb ? i : n - 1 - i; endfunction

  task automatic chk(string sig, string rq, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s/%s %s act=%0h exp=%0h t=%0t", cur_tag, rq, sig, act, exp, $time);
    end
  endtask

  // reference model: one current frame, one frame taken at the coming edge
  bit          f_on = 0, p_on = 0;
  int          f_t, f_n, f_pre, f_div, f_post, f_gap;
  bit          f_lsb, f_cpol, f_cpha, f_hold;
  logic [15:0] f_tx, f_rx;
  int          p_n, p_pre, p_div, p_post, p_gap;
  bit          p_lsb, p_cpol, p_cpha, p_hold;
  logic [15:0] p_tx, p_rx;
  int          seq = 0;

  always begin
    @(negedge clk); #1;
    if (rst_n && !finished) begin
      int k, tl, te, j;
      logic e_cs, e_sc, e_mo, e_rdy, e_rv;
      if (p_on) begin
        f_on = 1; f_t = 0; p_on = 0;
        f_n = p_n; f_pre = p_pre; f_div = p_div; f_post = p_post; f_gap = p_gap;
        f_lsb = p_lsb; f_cpol = p_cpol; f_cpha = p_cpha; f_hold = p_hold;
        f_tx = p_tx; f_rx = p_rx;
      end else if (f_on) f_t++;

      k = 0; te = 0;
      if (!f_on) begin
        e_cs = 1; e_sc = 0; e_mo = 0; e_rdy = 1; e_rv = 0;
      end else begin
        tl = f_pre + (2 * f_n - 1) * f_div;
        te = tl + f_post;
        k  = (f_t < f_pre) ? 0 : (f_t - f_pre) / f_div + 1;
        if (k > 2 * f_n) k = 2 * f_n;
        e_cs = (f_t < te) ? 1'b0 : 1'b1;
        e_sc = f_cpol ^ k[0];
        if (f_cpha) e_mo = (k == 0) ? 1'b0 : f_tx[wire_pos((k - 1) / 2, f_n, f_lsb)];
        else        e_mo = f_tx[wire_pos(((k / 2) > f_n - 1) ? f_n - 1 : k / 2, f_n, f_lsb)];
        e_rdy = (f_hold && f_t == te - 1) || (f_t >= te + f_gap);
        e_rv  = (f_t == tl);
      end
      chk("spi_cs_n",  "R7",  16'(spi_cs_n),  16'(e_cs));
      chk("spi_sclk",  "R3",  16'(spi_sclk),  16'(e_sc));
      chk("spi_mosi",  "R6",  16'(spi_mosi),  16'(e_mo));
      chk("cmd_ready", "R8",  16'(cmd_ready), 16'(e_rdy));
      chk("rx_valid",  "R11", 16'(rx_valid),  16'(e_rv));
      if (e_rv) chk("rx_word", "R6", rx_word, f_rx & 16'((32'h1 << f_n) - 1));

      // serial input: next bit to be sampled, by edges already made
      if (f_on && f_t < te) begin
        j = f_cpha ? k / 2 : (k + 1) / 2;
        spi_miso = (j < f_n) ? f_rx[wire_pos(j, f_n, f_lsb)] : 1'b0;
      end else spi_miso = 1'b0;

      if (cmd_valid && cmd_ready) begin
        seq++;
        p_on = 1;
        p_n = fit_len(int'(cmd_len));
        p_pre = at_least1(int'(cfg_lead)); p_div = at_least1(int'(cfg_half));
        p_post = at_least1(int'(cfg_trail)); p_gap = at_least1(int'(cfg_gap));
        p_lsb = cmd_lsb_first; p_cpol = cmd_cpol; p_cpha = cmd_cpha; p_hold = cmd_hold_cs;
        p_tx = cmd_word;
        p_rx = {cmd_word[7:0], cmd_word[15:8]} ^ 16'h5A3C ^ 16'(seq * 16'h1111);
      end
    end
  end

  task automatic send(logic [15:0] w, int n, bit lsb, bit cpol, bit cpha, bit hold);
    bit hs;
    @(negedge clk);
    cmd_word = w; cmd_len = 5'(n); cmd_lsb_first = lsb;
    cmd_cpol = cpol; cmd_cpha = cpha; cmd_hold_cs = hold; cmd_valid = 1'b1;
    do begin
      #1; hs = cmd_ready;
      @(posedge clk);
      if (!hs) @(negedge clk);
    end while (!hs);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic settle();
    do @(negedge clk); while (!(f_on && spi_cs_n === 1'b1 && cmd_ready === 1'b1) || p_on);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_cfg(int h, int l, int t, int g);
    @(negedge clk);
    cfg_half = 8'(h); cfg_lead = 8'(l); cfg_trail = 8'(t); cfg_gap = 8'(g);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    cur_tag = "R1";
    chk("spi_cs_n",  "R1", 16'(spi_cs_n), 16'd1);
    chk("spi_sclk",  "R1", 16'(spi_sclk), 16'd0);
    chk("cmd_ready", "R1", 16'(cmd_ready), 16'd1);
    chk("rx_valid",  "R1", 16'(rx_valid), 16'd0);

    cur_tag = "R4"; set_cfg(2, 3, 2, 4);
    send(16'h00A5, 8, 0, 0, 0, 0); settle();
    cur_tag = "R5"; set_cfg(1, 2, 1, 2);
    send(16'h003C, 8, 1, 1, 1, 0); settle();
    cur_tag = "R6"; set_cfg(2, 1, 3, 1);
    send(16'h0B6D, 12, 1, 1, 0, 0); settle();
    send(16'h0013, 5, 0, 0, 1, 0); settle();
    cur_tag = "R3"; set_cfg(3, 2, 2, 2);
    send(16'hC3E1, 16, 0, 0, 1, 0); settle();
    send(16'h9F0F, 20, 1, 0, 0, 0); settle();
    send(16'h0006, 2, 0, 1, 1, 0); settle();
    cur_tag = "R2"; set_cfg(1, 7, 1, 3);
    send(16'h005A, 6, 0, 0, 0, 0); settle();
    cur_tag = "R8"; set_cfg(1, 1, 2, 6);
    send(16'h00F1, 4, 0, 0, 0, 0);
    send(16'h000E, 4, 1, 0, 1, 0); settle();
    cur_tag = "R9"; set_cfg(2, 2, 3, 2);
    send(16'h1234, 9, 0, 0, 1, 1);
    send(16'h0ABC, 12, 1, 0, 1, 1);
    send(16'h0077, 7, 0, 0, 1, 0); settle();
    cur_tag = "R10";
    send(16'h00C9, 8, 0, 1, 0, 1); settle();
    cur_tag = "R12"; set_cfg(0, 0, 0, 0);
    send(16'h0E5B, 11, 0, 0, 0, 0);
    send(16'h02D7, 10, 1, 1, 1, 0); settle();

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL %s watchdog expired", cur_tag);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule